// File: doc/BRIEF.md
# CCD Capture Sequencer

This block walks a frame-transfer CCD through one complete capture. On a start request it pulses the overflow drain, waits out the integration time, and clocks the image and storage gates to move the frame into the masked store. It then asks the analog front end to load its configuration and waits for that loader to acknowledge. Finally it clocks the serial register and the reset gate to read the frame out, while the converter output and the frame memory are enabled. After readout it parks every clock at its idle level and flags completion.

All timing counts strobes on a `tick` input. In the target system `tick` fires every 62.5 ns, so 16 ticks make one microsecond. The default lengths follow from that: a 1 µs drain pulse, about 15.6 µs of integration, about 100 µs of parallel transfer, and 684 serial pulses plus one marker pulse. Every length is a parameter, so the same logic can run with short counts.

Top module: `ccd_capture_seq`

## Requirements
- R1: The `phase` output steps through a fixed order and never skips or repeats a phase: idle (0), drain (1), integration (2), parallel transfer (3), front-end configuration (4), serial readout (5), then back to idle (0).
- R2: Timed phases advance only on clock edges where `tick` is high. `drain_n` (active low) is low for exactly DRAIN_TICKS ticks. The integration phase (code 2) lasts exactly INTEG_TICKS ticks.
- R3: During parallel transfer, `gate_n` and `sreg_n` (both active low) are low together for exactly XFER_TICKS ticks. `gate_n` is never low while `sreg_n` is high.
- R4: `cfg_load` is high for exactly one cycle, the first cycle of phase 4. The sequencer leaves phase 4 on the edge after the first cycle where `cfg_ack` is high. `cfg_ack` has no effect outside phase 4 or during the `cfg_load` cycle.
- R5: Serial readout produces SREG_PULSES+1 falling edges on `sreg_n`. Each pulse is SREG_LOW_TICKS ticks low followed by SREG_HIGH_TICKS ticks high. `adc_oe_n` and `mem_ce_n` (active low) are both low for the whole of phase 5 and at no other time.
- R6: `rclk` (active high) follows the serial clock by one tick. After each tick edge, `rclk` equals (phase was 5 and `sreg_n` was low) at that edge. Between ticks it holds its value. It is never high outside readout.
- R7: When readout ends, the block returns to idle. `done` goes high for exactly one cycle, the first idle cycle, and all clocks and enables are at their idle levels.
- R8: `start` is acted on only in idle. In idle without `start` the phase stays 0. A `start` during a capture does not change the capture's order or durations.
- R9: Synchronous active-high `srst` puts the block in idle on the next edge. After that edge `drain_n`, `gate_n`, `sreg_n`, `adc_oe_n` and `mem_ce_n` are high, and `rclk`, `cfg_load` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase strobe, one per 62.5 ns interval |
| start | input | 1 | Begin a capture (accepted only in idle) |
| cfg_ack | input | 1 | Front-end configuration loader finished |
| drain_n | output | 1 | Overflow-drain clock, active low |
| gate_n | output | 1 | Image/storage gate clock enable, active low |
| sreg_n | output | 1 | Serial-register clock, active low |
| rclk | output | 1 | Reset-gate clock, active high |
| adc_oe_n | output | 1 | Converter output enable, active low |
| mem_ce_n | output | 1 | Frame memory enable, active low |
| cfg_load | output | 1 | One-cycle trigger to the configuration loader |
| phase | output | 3 | Current phase code |
| done | output | 1 | One-cycle pulse when readout completes |

## Verification
The bench thins `tick` to several densities. A design that counted clock cycles instead of ticks would then produce drain, integration, transfer and pulse lengths that no longer match the tick totals. The bench also drives stray `cfg_ack` and `start` strobes outside their windows. A decoder that obeyed them would leave phase 4 early or restart the capture, which breaks the phase order or the per-phase counts. It tracks `rclk` against the serial clock one tick earlier, which exposes a reset clock that is decoded directly, lags by the wrong amount, or stays high after readout. Finally, it resets in the middle of readout while `rclk` is high, to catch a reset that leaves a clock active.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DRAIN = 3'd1,
    PH_INTEG = 3'd2,
    PH_XFER  = 3'd3,
    PH_CFG   = 3'd4,
    PH_READ  = 3'd5
  } phase_e;

  // successor in the fixed capture order
  function automatic phase_e next_phase(input phase_e p);
    case (p)
      PH_IDLE:  return PH_DRAIN;
      PH_DRAIN: return PH_INTEG;
      PH_INTEG: return PH_XFER;
      PH_XFER:  return PH_CFG;
      PH_CFG:   return PH_READ;
      default:  return PH_IDLE;
    endcase
  endfunction

  // bits needed to hold values 0 .. n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // serial pulses per readout: the pixel pulses plus one marker pulse
  function automatic int unsigned sreg_total(input int unsigned pixels);
    return pixels + 1;
  endfunction

endpackage

// File: rtl/ccd_seq_timer.sv
module ccd_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] len,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  // fires on the tick that completes len ticks
  assign expire = tick && !clr && (cnt_q == len - W'(1));

  always_ff @(posedge clk) begin
    if (srst || clr)  cnt_q <= '0;
    else if (expire)  cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/ccd_seq_serial.sv
module ccd_seq_serial import ccd_seq_pkg::*; #(
  parameter int unsigned PIXELS    = 684,
  parameter int unsigned LOW_TICKS = 1,
  parameter int unsigned HIGH_TICKS = 1
) (
  input  logic clk,
  input  logic srst,
  input  logic run,
  input  logic tick,
  output logic sreg_low,
  output logic last_done
);
  localparam int unsigned PER   = LOW_TICKS + HIGH_TICKS;
  localparam int unsigned TOTAL = sreg_total(PIXELS);
  localparam int unsigned SW    = cnt_width(PER);
  localparam int unsigned PW    = cnt_width(TOTAL);

  logic [SW-1:0] sub_q;
  logic [PW-1:0] idx_q;
  logic          period_end;

  assign period_end = run && tick && (sub_q == SW'(PER - 1));
  assign sreg_low   = run && (sub_q < SW'(LOW_TICKS));
  assign last_done  = period_end && (idx_q == PW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (srst || !run) begin
      sub_q <= '0;
      idx_q <= '0;
    end else if (period_end) begin
      sub_q <= '0;
      idx_q <= last_done ? '0 : idx_q + PW'(1);
    end else if (tick) begin
      sub_q <= sub_q + SW'(1);
    end
  end
endmodule

// File: rtl/ccd_seq_pins.sv
module ccd_seq_pins import ccd_seq_pkg::*; (
  input  logic   clk,
  input  logic   srst,
  input  logic   tick,
  input  phase_e phase_q,
  input  logic   sreg_low,
  input  logic   read_end,
  output logic   drain_n,
  output logic   gate_n,
  output logic   sreg_n,
  output logic   rclk,
  output logic   adc_oe_n,
  output logic   mem_ce_n,
  output logic   done
);
  logic in_read;
  logic sreg_on;
  logic rclk_q;
  logic done_q;

  assign in_read  = (phase_q == PH_READ);
  assign sreg_on  = (phase_q == PH_XFER) || sreg_low;

  assign drain_n  = !(phase_q == PH_DRAIN);
  assign gate_n   = !(phase_q == PH_XFER);
  assign sreg_n   = !sreg_on;
  assign adc_oe_n = !in_read;
  assign mem_ce_n = !in_read;

  // reset gate trails the serial clock by one tick
  always_ff @(posedge clk) begin
    if (srst)      rclk_q <= 1'b0;
    else if (tick) rclk_q <= in_read && sreg_low;
  end

  always_ff @(posedge clk) begin
    if (srst) done_q <= 1'b0;
    else      done_q <= read_end;
  end

  assign rclk = rclk_q;
  assign done = done_q;
endmodule

// File: rtl/ccd_capture_seq.sv
module ccd_capture_seq import ccd_seq_pkg::*; #(
  parameter int unsigned DRAIN_TICKS     = 16,
  parameter int unsigned INTEG_TICKS     = 250,
  parameter int unsigned XFER_TICKS      = 1600,
  parameter int unsigned SREG_PULSES     = 684,
  parameter int unsigned SREG_LOW_TICKS  = 1,
  parameter int unsigned SREG_HIGH_TICKS = 1
) (
  input  logic       clk,
  input  logic       srst,
  input  logic       tick,
  input  logic       start,
  input  logic       cfg_ack,
  output logic       drain_n,
  output logic       gate_n,
  output logic       sreg_n,
  output logic       rclk,
  output logic       adc_oe_n,
  output logic       mem_ce_n,
  output logic       cfg_load,
  output logic [2:0] phase,
  output logic       done
);
  localparam int unsigned LEN_MAX = max3(DRAIN_TICKS, INTEG_TICKS, XFER_TICKS);
  localparam int unsigned TW      = cnt_width(LEN_MAX + 1);

  phase_e        phase_q, phase_d;
  logic [TW-1:0] len_sel;
  logic          timed, tmr_exp, cfg_sent_q, sreg_low;
  // named internal events
  logic          start_accept, timed_end, cfg_accept, read_end, advance;

  assign timed = (phase_q == PH_DRAIN) || (phase_q == PH_INTEG) || (phase_q == PH_XFER);

  always_comb begin
    case (phase_q)
      PH_DRAIN: len_sel = TW'(DRAIN_TICKS);
      PH_INTEG: len_sel = TW'(INTEG_TICKS);
      PH_XFER:  len_sel = TW'(XFER_TICKS);
      default:  len_sel = TW'(1);
    endcase
  end

  ccd_seq_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .srst   (srst),
    .clr    (!timed),
    .tick   (tick),
    .len    (len_sel),
    .expire (tmr_exp)
  );

  ccd_seq_serial #(
    .PIXELS     (SREG_PULSES),
    .LOW_TICKS  (SREG_LOW_TICKS),
    .HIGH_TICKS (SREG_HIGH_TICKS)
  ) u_serial (
    .clk       (clk),
    .srst      (srst),
    .run       (phase_q == PH_READ),
    .tick      (tick),
    .sreg_low  (sreg_low),
    .last_done (read_end)
  );

  assign start_accept = (phase_q == PH_IDLE) && start;
  assign timed_end    = timed && tmr_exp;
  assign cfg_load     = (phase_q == PH_CFG) && !cfg_sent_q;
  assign cfg_accept   = (phase_q == PH_CFG) && cfg_sent_q && cfg_ack;
  assign advance      = start_accept || timed_end || cfg_accept || read_end;
  assign phase_d      = advance ? next_phase(phase_q) : phase_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      phase_q    <= PH_IDLE;
      cfg_sent_q <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      cfg_sent_q <= (phase_q == PH_CFG);
    end
  end

  ccd_seq_pins u_pins (
    .clk      (clk),
    .srst     (srst),
    .tick     (tick),
    .phase_q  (phase_q),
    .sreg_low (sreg_low),
    .read_end (read_end),
    .drain_n  (drain_n),
    .gate_n   (gate_n),
    .sreg_n   (sreg_n),
    .rclk     (rclk),
    .adc_oe_n (adc_oe_n),
    .mem_ce_n (mem_ce_n),
    .done     (done)
  );

  assign phase = phase_q;
endmodule

// File: rtl/ccd_seq_checker.sv
module ccd_seq_checker (
  input logic       clk,
  input logic       srst,
  input logic       tick,
  input logic       drain_n,
  input logic       gate_n,
  input logic       sreg_n,
  input logic       rclk,
  input logic       adc_oe_n,
  input logic       mem_ce_n,
  input logic       cfg_load,
  input logic [2:0] phase,
  input logic       done,
  input logic       read_end
);
  a_r1_phase_order: assert property (@(posedge clk) disable iff (srst)
    (phase != $past(phase)) |->
      (phase == (($past(phase) == 3'd5) ? 3'd0 : $past(phase) + 3'd1)));

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (srst)
    (!tick && (phase == 3'd1 || phase == 3'd2 || phase == 3'd3 || phase == 3'd5))
      |=> (phase == $past(phase)));

  a_r3_gate_with_sreg: assert property (@(posedge clk) disable iff (srst)
    !gate_n |-> !sreg_n);

  a_r4_load_single: assert property (@(posedge clk) disable iff (srst)
    cfg_load |=> !cfg_load);

  a_r4_load_in_cfg: assert property (@(posedge clk) disable iff (srst)
    cfg_load |-> (phase == 3'd4));

  a_r5_end_on_tick: assert property (@(posedge clk) disable iff (srst)
    read_end |-> tick);

  a_r5_enables_paired: assert property (@(posedge clk) disable iff (srst)
    (adc_oe_n == mem_ce_n));

  a_r6_rclk_after_sreg: assert property (@(posedge clk) disable iff (srst)
    $rose(rclk) |-> ($past(tick) && !$past(sreg_n) && $past(phase) == 3'd5));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (srst)
    done |=> !done);

  a_r7_done_after_read: assert property (@(posedge clk) disable iff (srst)
    done |-> ($past(phase) == 3'd5 && phase == 3'd0));

  a_r9_idle_levels: assert property (@(posedge clk) disable iff (srst)
    (phase == 3'd0) |-> (drain_n && gate_n && sreg_n && !rclk && adc_oe_n && mem_ce_n));
endmodule

bind ccd_capture_seq ccd_seq_checker u_chk (
  .clk      (clk),
  .srst     (srst),
  .tick     (tick),
  .drain_n  (drain_n),
  .gate_n   (gate_n),
  .sreg_n   (sreg_n),
  .rclk     (rclk),
  .adc_oe_n (adc_oe_n),
  .mem_ce_n (mem_ce_n),
  .cfg_load (cfg_load),
  .phase    (phase),
  .done     (done),
  .read_end (read_end)
);

// File: tb/tb_ccd_capture_seq.sv
`timescale 1ns/1ps
module tb_ccd_capture_seq;
  localparam int DRAIN = 5;
  localparam int INTEG = 9;
  localparam int XFER  = 12;
  localparam int PIX   = 6;
  localparam int LOWT  = 2;
  localparam int HIGHT = 3;

  logic clk = 1'b0;
  logic srst = 1'b1, tick = 1'b0, start = 1'b0, cfg_ack = 1'b0;
  logic drain_n, gate_n, sreg_n, rclk, adc_oe_n, mem_ce_n, cfg_load, done;
  logic [2:0] phase;

  ccd_capture_seq #(
    .DRAIN_TICKS(DRAIN), .INTEG_TICKS(INTEG), .XFER_TICKS(XFER),
    .SREG_PULSES(PIX), .SREG_LOW_TICKS(LOWT), .SREG_HIGH_TICKS(HIGHT)
  ) dut (
    .clk(clk), .srst(srst), .tick(tick), .start(start), .cfg_ack(cfg_ack),
    .drain_n(drain_n), .gate_n(gate_n), .sreg_n(sreg_n), .rclk(rclk),
    .adc_oe_n(adc_oe_n), .mem_ce_n(mem_ce_n), .cfg_load(cfg_load),
    .phase(phase), .done(done)
  );

  always #5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int tick_pct = 100;
  bit spurious = 0, start_req = 0, have_prev = 0;
  int ack_cnt = 0;

  // per-capture tallies
  int drain_t, integ_t, gate_t, low_t, high_t, falls, loads, dones;
  int gate_mis, oe_mis, rclk_bad, order_bad, trans, cfg_bad, done_bad;
  logic p_sreg, p_rclk, p_tick, p_ro, p_ack;
  logic [2:0] p_phase;

  function automatic int exp_falls();     return PIX + 1;          endfunction
  function automatic int exp_low_ticks(); return (PIX + 1) * LOWT;  endfunction
  function automatic int exp_high_ticks();return (PIX + 1) * HIGHT; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    drain_t = 0; integ_t = 0; gate_t = 0; low_t = 0; high_t = 0; falls = 0;
    loads = 0; dones = 0; gate_mis = 0; oe_mis = 0; rclk_bad = 0;
    order_bad = 0; trans = 0; cfg_bad = 0; done_bad = 0;
  endtask

  task automatic step();
    logic exp_r;
    @(negedge clk);
    if (have_prev) begin
      exp_r = p_tick ? (p_ro && !p_sreg) : p_rclk;
      if (rclk !== exp_r) rclk_bad++;
      if (phase != p_phase) begin
        trans++;
        if (phase != ((p_phase == 3'd5) ? 3'd0 : p_phase + 3'd1)) order_bad++;
        if (p_phase == 3'd4 && !p_ack) cfg_bad++;
      end else if (p_phase == 3'd4 && p_ack && !p_ro && !loads_pending()) begin
        cfg_bad++;
      end
    end
    if (done) begin dones++; if (phase != 3'd0) done_bad++; end
    if (cfg_load) loads++;
    if (!gate_n && sreg_n) gate_mis++;
    if (adc_oe_n != mem_ce_n) oe_mis++;
    if (!adc_oe_n && !sreg_n && p_sreg && have_prev) falls++;
    // drive inputs for the coming edge
    tick = ($urandom_range(99) < tick_pct);
    if (start_req) begin start = 1'b1; start_req = 0; end
    else start = spurious && (phase != 3'd0) && ($urandom_range(99) < 8);
    if (ack_cnt > 0) begin
      ack_cnt--;
      cfg_ack = (ack_cnt == 0);
    end else begin
      cfg_ack = spurious && (phase != 3'd4) && ($urandom_range(99) < 8);
    end
    if (cfg_load) ack_cnt = $urandom_range(4, 1);
    if (tick) begin
      if (!drain_n) drain_t++;
      if (phase == 3'd2) integ_t++;
      if (!gate_n) gate_t++;
      if (!adc_oe_n) begin if (!sreg_n) low_t++; else high_t++; end
    end
    p_sreg = sreg_n; p_rclk = rclk; p_tick = tick; p_ro = !adc_oe_n;
    p_phase = phase; p_ack = cfg_ack && !cfg_load; have_prev = 1;
  endtask

  // an ack in the cycle of cfg_load must not count as an exit request
  function automatic bit loads_pending();
    return 1'b0;
  endfunction

  task automatic run_capture(input int pct, input bit spur);
    int guard;
    clear_stats();
    tick_pct = pct; spurious = spur; start_req = 1;
    guard = 0;
    while (dones == 0 && guard < 4000) begin step(); guard++; end
    chk(guard < 4000, "R7 watchdog: capture finished", guard, 4000);
    spurious = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      if (phase != 3'd0) order_bad++;
    end
    chk(order_bad == 0 && trans == 6, "R1 phase order/transitions", trans, 6);
    chk(drain_t == DRAIN, "R2 drain ticks", drain_t, DRAIN);
    chk(integ_t == INTEG, "R2 integration ticks", integ_t, INTEG);
    chk(gate_t == XFER, "R3 transfer ticks", gate_t, XFER);
    chk(gate_mis == 0, "R3 gate without serial clock", gate_mis, 0);
    chk(loads == 1, "R4 cfg_load pulses", loads, 1);
    chk(cfg_bad == 0, "R4 config exit only on ack", cfg_bad, 0);
    chk(falls == exp_falls(), "R5 serial pulses", falls, exp_falls());
    chk(low_t == exp_low_ticks(), "R5 serial low ticks", low_t, exp_low_ticks());
    chk(high_t == exp_high_ticks(), "R5 serial high ticks", high_t, exp_high_ticks());
    chk(oe_mis == 0, "R5 enables paired", oe_mis, 0);
    chk(rclk_bad == 0, "R6 rclk one tick behind", rclk_bad, 0);
    chk(dones == 1 && done_bad == 0, "R7 done single pulse in idle", dones, 1);
    chk(phase == 3'd0, "R8 idle holds without start", phase, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    srst = 1'b0;
    @(negedge clk);
    chk(phase == 3'd0 && !done && !cfg_load, "R9 reset phase", phase, 0);
    chk(drain_n && gate_n && sreg_n && !rclk && adc_oe_n && mem_ce_n,
        "R9 reset pin levels", {drain_n, gate_n, sreg_n, rclk, adc_oe_n, mem_ce_n}, 6'b111011);
    for (int i = 0; i < 10; i++) step();
    chk(phase == 3'd0, "R8 no start stays idle", phase, 0);

    run_capture(100, 0);
    run_capture(60, 1);
    run_capture(30, 1);
    run_capture(85, 1);

    // R9: reset in readout while the reset gate is high
    tick_pct = 100; spurious = 0; start_req = 1;
    for (int g = 0; g < 4000; g++) begin
      step();
      if (phase == 3'd5 && rclk) break;
    end
    chk(phase == 3'd5 && rclk, "R9 reached readout with rclk high", rclk, 1);
    srst = 1'b1; start = 1'b0; cfg_ack = 1'b0;
    @(negedge clk);
    srst = 1'b0;
    chk(phase == 3'd0 && !done && !cfg_load, "R9 mid-readout reset phase", phase, 0);
    chk(drain_n && gate_n && sreg_n && !rclk && adc_oe_n && mem_ce_n,
        "R9 mid-readout reset pins", {drain_n, gate_n, sreg_n, rclk, adc_oe_n, mem_ce_n}, 6'b111011);
    have_prev = 0;
    run_capture(70, 1);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule